// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Datapath

This block runs one instruction on every clock edge. Each instruction is fetched from an instruction memory attached at the ports, decoded, and completed in that same cycle. The block holds the program counter, a register file of thirty-two 32-bit registers with two read ports and one write port, an ALU with a zero output, a 16-bit sign extender and the branch-target adder. A small decoder turns the opcode and function fields into the ALU operation, the mux selects and the write enables.

The instruction set covers register-register add, subtract, AND, OR and signed set-less-than, add-immediate, word load, word store and branch-if-equal. Data memory sits outside the block. The block presents an address, store data and separate read and write strobes, and it takes load data back combinationally in the same cycle. Register 0 is hard-wired to zero. Reset is synchronous and active low.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the PC becomes 0 (`imem_addr` = 0 after that edge). While `rst_n` is low, `dmem_we` is 0 and no register is written.
- R2: An instruction that is not a taken branch loads PC+4 into the PC at the next edge.
- R3: R-type instructions (opcode 0x00) write rd (bits 15:11) with rs (25:21) op rt (20:16). The funct field (bits 5:0) selects the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than, which gives 1 or 0.
- R4: addi (opcode 0x08) writes rt with rs plus the 16-bit immediate (bits 15:0), sign-extended.
- R5: lw (opcode 0x23) drives `dmem_addr` = rs + sext(imm) and sets `dmem_re`. It writes `dmem_rdata` into rt.
- R6: sw (opcode 0x2B) drives `dmem_addr` = rs + sext(imm) and `dmem_wdata` = rt, and sets `dmem_we`. It writes no register. `dmem_re` and `dmem_we` are never 1 together.
- R7: beq (opcode 0x04) with rs equal to rt loads PC+4+(sext(imm)<<2) into the PC, and a negative offset branches backwards. With rs not equal to rt it loads PC+4.
- R8: Register 0 always reads zero. Writes aimed at it are discarded.
- R9: A register written at an edge holds the new value for the instructions that follow. Chains of dependent instructions on successive cycles therefore compute correctly.
- R10: An unknown opcode, or an unknown funct under opcode 0x00, writes no register and no memory. The PC still advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 32 | Current PC, byte address of the instruction |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Data memory byte address (ALU result) |
| dmem_wdata | output | 32 | Store data (rt operand) |
| dmem_re | output | 1 | Data memory read strobe (load) |
| dmem_we | output | 1 | Data memory write strobe (store) |
| dmem_rdata | input | 32 | Load data returned in the same cycle |

## Verification
The only visible state is the PC on `imem_addr` and the data-memory traffic. A corrupted register therefore shows up only when a later store or branch uses it. The directed programs store every computed result, so a bad ALU operation, immediate extension or writeback choice appears in memory a few cycles later. A wrong PC update shows on `imem_addr` at the very next edge, and the bench samples the PC right after each branch. Strobe and address faults appear combinationally in the cycle the load or store is presented.

// File: rtl/sc_pkg.sv
// Shared definitions for the single-cycle core: instruction field widths,
// opcode and funct codes, ALU operations and the decoded control bundle.
// Assumes the fixed 32-bit R/I instruction layout described in the brief.
package sc_pkg;

    localparam int REG_IDX_W = 5;
    localparam int NUM_REGS  = 1 << REG_IDX_W;
    localparam int IMM_W     = 16;

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_ADDI  = 6'h08;
    localparam logic [5:0] OPC_LW    = 6'h23;
    localparam logic [5:0] OPC_SW    = 6'h2B;
    localparam logic [5:0] OPC_BEQ   = 6'h04;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alu_op_e;

    typedef struct packed {
        logic    reg_we;      // instruction writes a register
        logic    dst_is_rd;   // destination is rd (else rt)
        logic    b_is_imm;    // ALU operand B is the sign-extended immediate
        logic    mem_re;      // load
        logic    mem_we;      // store
        logic    wb_from_mem; // writeback takes load data
        logic    is_branch;   // branch on ALU zero
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/sc_decoder.sv
// Control decoder: maps opcode and funct to the control bundle.
// Assumes: unknown opcodes and unknown R-type funct codes decode to an
// all-inactive bundle, so they behave as a no-op.
module sc_decoder
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    // Purpose: combinational opcode/funct decode.
    always_comb begin
        ctrl = '{reg_we: 1'b0, dst_is_rd: 1'b0, b_is_imm: 1'b0, mem_re: 1'b0,
                 mem_we: 1'b0, wb_from_mem: 1'b0, is_branch: 1'b0, alu_op: ALU_ADD};
        unique case (opcode)
            OPC_RTYPE: begin
                ctrl.dst_is_rd = 1'b1;
                ctrl.reg_we    = 1'b1;
                unique case (funct)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    default: ctrl.reg_we = 1'b0;
                endcase
            end
            OPC_ADDI: begin
                ctrl.reg_we   = 1'b1;
                ctrl.b_is_imm = 1'b1;
            end
            OPC_LW: begin
                ctrl.reg_we      = 1'b1;
                ctrl.b_is_imm    = 1'b1;
                ctrl.mem_re      = 1'b1;
                ctrl.wb_from_mem = 1'b1;
            end
            OPC_SW: begin
                ctrl.b_is_imm = 1'b1;
                ctrl.mem_we   = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.is_branch = 1'b1;
                ctrl.alu_op    = ALU_SUB;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
// Register file: NREG x W, two combinational read ports, one write port.
// Assumes: entry 0 has no storage and reads zero; contents are not reset;
// a read in the cycle of a write returns the old value.
module sc_regfile #(
    parameter int W    = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata
);

    logic [W-1:0] bank [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (g == 0) begin : g_zero
            assign bank[g] = '0;
        end else begin : g_live
            logic [W-1:0] q;
            // Purpose: capture write data for this entry on its write strobe.
            always_ff @(posedge clk) begin
                if (we && waddr == AW'(g)) q <= wdata;
            end
            assign bank[g] = q;
        end
    end

    assign rdata_a = bank[raddr_a];
    assign rdata_b = bank[raddr_b];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr != '0) |=> bank[$past(waddr)] == $past(wdata)); // R9

endmodule

// File: rtl/sc_alu.sv
// ALU: add, subtract, AND, OR and signed set-less-than on W-bit operands.
// Assumes: overflow is ignored; zero reflects the selected result.
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);

    // Purpose: select the operation result.
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_core.sv
// Single-cycle core top: PC, fetch, decode, register file, ALU, memory
// strobes and writeback, one instruction per clock.
// Assumes: instruction and data memories answer combinationally; reset is
// synchronous active-low and blocks all writes while low.
module sc_core
    import sc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_re,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata
);

    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [XLEN-1:0]      pc_q, pc_next, pc_plus4, br_target;
    logic [5:0]           opcode, funct;
    logic [REG_IDX_W-1:0] rs_idx, rt_idx, rd_idx, wr_idx;
    logic [IMM_W-1:0]     imm;
    logic [XLEN-1:0]      imm_ext, rs_val, rt_val, alu_b, alu_y, wb_val;
    logic                 alu_zero, take_br, rf_we;
    ctrl_t                ctrl;
    logic                 unused_shamt;

    assign opcode = imem_rdata[31:26];
    assign rs_idx = imem_rdata[25:21];
    assign rt_idx = imem_rdata[20:16];
    assign rd_idx = imem_rdata[15:11];
    assign funct  = imem_rdata[5:0];
    assign imm    = imem_rdata[15:0];
    assign unused_shamt = ^imem_rdata[10:6];

    sc_decoder u_dec (
        .opcode (opcode),
        .funct  (funct),
        .ctrl   (ctrl)
    );

    assign imm_ext = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    assign wr_idx  = ctrl.dst_is_rd ? rd_idx : rt_idx;
    assign rf_we   = ctrl.reg_we & rst_n;

    sc_regfile #(.W(XLEN), .NREG(NUM_REGS)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .raddr_a (rs_idx),
        .raddr_b (rt_idx),
        .rdata_a (rs_val),
        .rdata_b (rt_val),
        .we      (rf_we),
        .waddr   (wr_idx),
        .wdata   (wb_val)
    );

    assign alu_b = ctrl.b_is_imm ? imm_ext : rt_val;

    sc_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Writeback mux: load data or ALU result.
    assign wb_val = ctrl.wb_from_mem ? dmem_rdata : alu_y;

    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;
    assign dmem_re    = ctrl.mem_re & rst_n;
    assign dmem_we    = ctrl.mem_we & rst_n;

    // Next-PC: sequential adder and branch-target adder.
    assign pc_plus4  = pc_q + STEP;
    assign br_target = pc_plus4 + (imm_ext << 2);
    assign take_br   = ctrl.is_branch & alu_zero;
    assign pc_next   = take_br ? br_target : pc_plus4;

    // Purpose: PC register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end

    assign imem_addr = pc_q;

    AST_PC_RESET: assert property (@(posedge clk)
        !rst_n |=> pc_q == '0); // R1
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl.is_branch && alu_zero) |=> pc_q == $past(pc_q) + STEP); // R2
    AST_BR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.is_branch && rs_val == rt_val) |=>
        pc_q == $past(pc_q) + STEP + ($past(imm_ext) << 2)); // R7
    AST_MEM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(dmem_re && dmem_we)); // R6
    AST_STORE_NOREG: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> !rf_we); // R6
    AST_R0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_idx == '0) |-> rs_val == '0); // R8

endmodule

// File: tb/test_sc_core.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario; memories are bench arrays.
module test_sc_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_re, dmem_we;
    logic [31:0] imem [64];
    logic [31:0] dmem [64];
    int          n_run = 0;
    int          n_fail = 0;
    int          cyc = 0;

    always #10 clk = ~clk;

    sc_core i_sc_core (
        .clk (clk), .rst_n (rst_n),
        .imem_addr (imem_addr), .imem_rdata (imem_rdata),
        .dmem_addr (dmem_addr), .dmem_wdata (dmem_wdata),
        .dmem_re (dmem_re), .dmem_we (dmem_we), .dmem_rdata (dmem_rdata)
    );

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];
    always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

    // Watchdog: counts as a failed check, still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    function automatic logic [31:0] rins(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction
    function automatic logic [31:0] iins(logic [5:0] op, int rs, int rt, int imm);
        return {op, rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) begin
            imem[i] = 32'h0;
            dmem[i] = 32'hDEADBEEF;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_pc_step();
        clear_mem();
        do_reset();
        chk("R1 pc after reset", imem_addr, 32'd0);
        run(1);
        chk("R2 pc step", imem_addr, 32'd4);
        run(3);
        chk("R2 pc step x3", imem_addr, 32'd16);
    endtask

    task automatic t_reset_blocks();
        imem[0] = iins(6'h2B, 0, 0, 0);     // sw r0,0(r0) at reset vector
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 pc cleared", imem_addr, 32'd0);
        chk("R1 no store in reset", {31'd0, dmem_we}, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_alu();
        clear_mem();
        imem[0]  = iins(6'h08, 0, 1, 7);
        imem[1]  = iins(6'h08, 0, 2, -3);
        imem[2]  = rins(1, 2, 3, 6'h20);
        imem[3]  = rins(1, 2, 4, 6'h22);
        imem[4]  = rins(1, 2, 5, 6'h24);
        imem[5]  = rins(1, 2, 6, 6'h25);
        imem[6]  = rins(2, 1, 7, 6'h2A);
        imem[7]  = rins(1, 2, 8, 6'h2A);
        for (int k = 0; k < 6; k++) imem[8+k] = iins(6'h2B, 0, 3+k, 4*k);
        do_reset();
        run(14);
        chk("R3 add", dmem[0], 32'd4);
        chk("R3 sub", dmem[1], 32'd10);
        chk("R3 and", dmem[2], 32'd5);
        chk("R3 or / R4 sign-extended addi", dmem[3], 32'hFFFFFFFF);
        chk("R3 slt true", dmem[4], 32'd1);
        chk("R3 slt false", dmem[5], 32'd0);
    endtask

    task automatic t_load_store();
        clear_mem();
        dmem[10] = 32'hCAFE1234;
        imem[0] = iins(6'h08, 0, 1, 48);
        imem[1] = iins(6'h23, 1, 2, -8);   // lw r2,-8(r1) -> 40
        imem[2] = iins(6'h2B, 1, 2, 4);    // sw r2,4(r1)  -> 52
        do_reset();
        run(1);
        chk("R5 load addr", dmem_addr, 32'd40);
        chk("R5 load re", {31'd0, dmem_re}, 32'd1);
        chk("R6 no we on load", {31'd0, dmem_we}, 32'd0);
        run(1);
        chk("R6 store addr", dmem_addr, 32'd52);
        chk("R6 store data / R5 load writeback", dmem_wdata, 32'hCAFE1234);
        chk("R6 store we", {31'd0, dmem_we}, 32'd1);
        chk("R6 no re on store", {31'd0, dmem_re}, 32'd0);
        run(1);
        chk("R6 store landed", dmem[13], 32'hCAFE1234);
    endtask

    task automatic t_branch();
        clear_mem();
        imem[0] = iins(6'h08, 0, 1, 5);
        imem[1] = iins(6'h08, 0, 2, 5);
        imem[2] = iins(6'h08, 0, 3, 9);
        imem[3] = iins(6'h04, 1, 2, 2);    // taken -> 24
        imem[4] = iins(6'h08, 0, 3, 1);
        imem[5] = iins(6'h08, 0, 3, 2);
        imem[6] = iins(6'h04, 1, 0, 5);    // not taken -> 28
        imem[7] = iins(6'h2B, 0, 3, 0);
        imem[8] = iins(6'h04, 0, 0, -1);   // loop on itself
        do_reset();
        run(3);
        chk("R7 at branch", imem_addr, 32'd12);
        run(1);
        chk("R7 taken target", imem_addr, 32'd24);
        run(1);
        chk("R7 not taken", imem_addr, 32'd28);
        run(1);
        chk("R7 skipped writes", dmem[0], 32'd9);
        run(1);
        chk("R7 backward target", imem_addr, 32'd32);
    endtask

    task automatic t_r0_and_chain();
        clear_mem();
        imem[0] = iins(6'h08, 0, 0, 55);   // addi r0 discarded
        imem[1] = iins(6'h2B, 0, 0, 4);    // sw r0,4(r0)
        imem[2] = iins(6'h08, 0, 2, 3);
        imem[3] = rins(2, 2, 2, 6'h20);
        imem[4] = rins(2, 2, 2, 6'h20);
        imem[5] = iins(6'h2B, 0, 2, 8);
        do_reset();
        run(6);
        chk("R8 r0 stays zero", dmem[1], 32'd0);
        chk("R9 dependent chain", dmem[2], 32'd12);
    endtask

    task automatic t_illegal();
        clear_mem();
        imem[0] = iins(6'h08, 0, 6, 17);
        imem[1] = iins(6'h3F, 0, 6, 34);   // unknown opcode
        imem[2] = rins(0, 0, 6, 6'h3F);    // unknown funct
        imem[3] = iins(6'h2B, 0, 6, 12);
        do_reset();
        run(1);
        chk("R10 no store on bad opcode", {31'd0, dmem_we}, 32'd0);
        run(1);
        chk("R10 pc advances", imem_addr, 32'd8);
        chk("R10 no store on bad funct", {31'd0, dmem_we}, 32'd0);
        run(2);
        chk("R10 register untouched", dmem[3], 32'd17);
    endtask

    initial begin
        clear_mem();
        t_pc_step();
        t_reset_blocks();
        t_alu();
        t_load_store();
        t_branch();
        t_r0_and_chain();
        t_illegal();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule